// File: doc/BRIEF.md
# Packed Integer SIMD Execution Unit

This block is a pipelined execution unit for 256-bit packed integers. Each operation brings two 256-bit operands, a 5-bit immediate, an element-size select, an operation code and a destination tag. The operand is split into equal lanes of 8, 16, 32 or 64 bits, and every lane is handled on its own. Carries do not cross lane borders. The supported operations are add, bitwise XOR, per-lane left shift, signed maximum against the second operand, signed maximum against a sign-extended immediate, and multiply.

Add, XOR, shift and both maximum forms take one cycle. Multiply takes four cycles and is fully pipelined. The unit has a single result port, so results leave in the order they finish, and an operation issued later can finish earlier. When a one-cycle operation would finish in the same cycle as a multiply already in the pipeline, the unit stalls the one-cycle operation by dropping `in_ready`. A multiply is never stalled. Each result leaves with the tag of the operation that produced it.

An upstream scheduler holds `in_valid` together with the operation fields until `in_ready` is high at a rising clock edge. That edge is the acceptance edge, and the scheduler watches `out_valid` to collect results.

Top module: `simd_int_unit`

## Requirements
- R1: `in_esz` selects the lane width: 0 gives 8-bit lanes, 1 gives 16, 2 gives 32 and 3 gives 64. Every lane result depends only on the same lane of the inputs.
- R2: Operation code 0 (add) returns the lane-wise sum modulo 2^width. The result is valid in the cycle after acceptance.
- R3: Operation code 1 (XOR) returns `in_a ^ in_b`. The result is valid in the cycle after acceptance.
- R4: Operation code 2 (shift) shifts each lane of `in_a` left and fills with zeros. The shift amount is the low log2(width) bits of the same lane of `in_b`, and the upper bits of that lane are ignored. The result is valid in the cycle after acceptance.
- R5: Operation code 3 (max) returns, per lane, the larger of the two lanes compared as signed two's complement numbers. The result is valid in the cycle after acceptance.
- R6: Operation code 4 (max-immediate) sign-extends `in_imm` (range -16..15) to the lane width and returns, per lane, the signed larger of the lane of `in_a` and that value. The result is valid in the cycle after acceptance.
- R7: Operation code 5 (multiply) returns, per lane, the low lane-width bits of the product. Its result is valid four cycles after the acceptance cycle, and one multiply can be accepted in every cycle.
- R8: `in_ready` is low exactly when a non-multiply operation is offered and a multiply will complete in the next cycle. A multiply is always accepted.
- R9: `out_valid` is high for exactly one cycle per accepted operation, in its completion cycle. `out_tag` carries that operation's `in_tag` in the same cycle.
- R10: While `rst_n` is low, `out_valid` is low. Operations in flight when reset is asserted never produce a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The offered operation is accepted at the next edge |
| in_op | input | 3 | Operation code (0 add, 1 xor, 2 shift, 3 max, 4 max-immediate, 5 multiply) |
| in_esz | input | 2 | Lane width select |
| in_imm | input | 5 | Signed immediate for max-immediate |
| in_a | input | 256 | First operand |
| in_b | input | 256 | Second operand |
| in_tag | input | 5 | Destination tag |
| out_valid | output | 1 | Result valid in this cycle |
| out_data | output | 256 | Result |
| out_tag | output | 5 | Tag of the result |

## Verification
A stall happens only when a multiply sits exactly three cycles ahead of a one-cycle operation, so random traffic alone reaches it only now and then. The stimulus therefore includes directed sequences: a multiply followed by back-to-back one-cycle operations, and bursts that mix multiplies with one-cycle operations. In these the held operation must wait exactly one cycle, and a later operation must finish before an earlier multiply. A reset is also asserted while multiplies are still in the pipeline, and the bench then checks that nothing comes out once reset is released.

// File: rtl/simd_int_pkg.sv
package simd_int_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_XOR  = 3'd1,
    OP_SLL  = 3'd2,
    OP_MAX  = 3'd3,
    OP_MAXI = 3'd4,
    OP_MUL  = 3'd5
  } simd_op_e;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } simd_esz_e;

  localparam int NUM_ESZ = 4;

endpackage

// File: rtl/simd_lane_alu.sv
// Single-cycle lane operations, purely combinational.
module simd_lane_alu
  import simd_int_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int IMM_W  = 5
) (
  input  simd_op_e             op,
  input  simd_esz_e            esz,
  input  logic [IMM_W-1:0]     imm,
  input  logic [DATA_W-1:0]    a,
  input  logic [DATA_W-1:0]    b,
  output logic [DATA_W-1:0]    res
);

  logic [DATA_W-1:0] by_size [NUM_ESZ];

  for (genvar g = 0; g < NUM_ESZ; g++) begin : g_size
    localparam int EW    = 8 << g;
    localparam int LANES = DATA_W / EW;
    localparam int SH_W  = $clog2(EW);

    logic [EW-1:0]     imm_x;
    logic [DATA_W-1:0] size_res;

    assign imm_x = {{(EW-IMM_W){imm[IMM_W-1]}}, imm};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [EW-1:0] ea;
      logic [EW-1:0] eb;
      logic [EW-1:0] er;

      assign ea = a[l*EW +: EW];
      assign eb = b[l*EW +: EW];

      always_comb begin
        case (op)
          OP_ADD:  er = ea + eb;
          OP_XOR:  er = ea ^ eb;
          OP_SLL:  er = ea << eb[SH_W-1:0];
          OP_MAX:  er = ($signed(ea) > $signed(eb))    ? ea : eb;
          OP_MAXI: er = ($signed(ea) > $signed(imm_x)) ? ea : imm_x;
          default: er = '0;
        endcase
      end

      assign size_res[l*EW +: EW] = er;
    end

    assign by_size[g] = size_res;
  end

  always_comb begin
    res = by_size[int'(esz)];
  end

endmodule

// File: rtl/simd_mul_pipe.sv
// Packed multiply, low half kept. Products are registered at acceptance,
// then carried through LAT-1 stages in total. The output register in the
// parent module is the last stage.
module simd_mul_pipe
  import simd_int_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int TAG_W  = 5,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  simd_esz_e         esz,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [TAG_W-1:0]  tag,
  output logic              tail_valid,
  output logic [DATA_W-1:0] tail_data,
  output logic [TAG_W-1:0]  tail_tag
);

  localparam int NSTG = LAT - 1;

  logic [DATA_W-1:0] prod_by_size [NUM_ESZ];
  logic [DATA_W-1:0] prod;

  for (genvar g = 0; g < NUM_ESZ; g++) begin : g_size
    localparam int EW    = 8 << g;
    localparam int LANES = DATA_W / EW;
    logic [DATA_W-1:0] size_prod;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign size_prod[l*EW +: EW] = a[l*EW +: EW] * b[l*EW +: EW];
    end

    assign prod_by_size[g] = size_prod;
  end

  always_comb begin
    prod = prod_by_size[int'(esz)];
  end

  // stage state and next state
  logic [NSTG-1:0]   stg_v;
  logic [NSTG-1:0]   stg_v_nxt;
  logic [DATA_W-1:0] stg_d [NSTG];
  logic [TAG_W-1:0]  stg_t [NSTG];
  logic [NSTG-1:0]   stg_en;

  always_comb begin
    stg_v_nxt[0] = issue;
    stg_en[0]    = issue;
    for (int s = 1; s < NSTG; s++) begin
      stg_v_nxt[s] = stg_v[s-1];
      stg_en[s]    = stg_v[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_v <= '0;
    else        stg_v <= stg_v_nxt;
  end

  always_ff @(posedge clk) begin
    if (stg_en[0]) begin
      stg_d[0] <= prod;
      stg_t[0] <= tag;
    end
    for (int s = 1; s < NSTG; s++) begin
      if (stg_en[s]) begin
        stg_d[s] <= stg_d[s-1];
        stg_t[s] <= stg_t[s-1];
      end
    end
  end

  assign tail_valid = stg_v[NSTG-1];
  assign tail_data  = stg_d[NSTG-1];
  assign tail_tag   = stg_t[NSTG-1];

endmodule

// File: rtl/simd_int_unit.sv
module simd_int_unit
  import simd_int_pkg::*;
#(
  parameter int DATA_W  = 256,
  parameter int TAG_W   = 5,
  parameter int IMM_W   = 5,
  parameter int MUL_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_esz,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag
);

  simd_op_e  op;
  simd_esz_e esz;
  logic      is_mul;
  logic      accept;
  logic      short_acc;
  logic      mul_acc;

  logic [DATA_W-1:0] alu_res;
  logic              mul_tail_v;
  logic [DATA_W-1:0] mul_tail_d;
  logic [TAG_W-1:0]  mul_tail_t;

  assign op     = simd_op_e'(in_op);
  assign esz    = simd_esz_e'(in_esz);
  assign is_mul = (op == OP_MUL);

  // single writeback port: a short op may not land on a finishing multiply
  assign in_ready  = !(mul_tail_v && !is_mul);
  assign accept    = in_valid && in_ready;
  assign short_acc = accept && !is_mul;
  assign mul_acc   = accept && is_mul;

  simd_lane_alu #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_alu (
    .op  (op),
    .esz (esz),
    .imm (in_imm),
    .a   (in_a),
    .b   (in_b),
    .res (alu_res)
  );

  simd_mul_pipe #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .LAT    (MUL_LAT)
  ) u_mul (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (mul_acc),
    .esz        (esz),
    .a          (in_a),
    .b          (in_b),
    .tag        (in_tag),
    .tail_valid (mul_tail_v),
    .tail_data  (mul_tail_d),
    .tail_tag   (mul_tail_t)
  );

  // writeback register: next state
  logic              wb_v_nxt;
  logic              wb_en;
  logic [DATA_W-1:0] wb_d_nxt;
  logic [TAG_W-1:0]  wb_t_nxt;

  always_comb begin
    wb_v_nxt = short_acc || mul_tail_v;
    wb_en    = wb_v_nxt;
    if (short_acc) begin
      wb_d_nxt = alu_res;
      wb_t_nxt = in_tag;
    end else begin
      wb_d_nxt = mul_tail_d;
      wb_t_nxt = mul_tail_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= wb_v_nxt;
  end

  always_ff @(posedge clk) begin
    if (wb_en) begin
      out_data <= wb_d_nxt;
      out_tag  <= wb_t_nxt;
    end
  end

endmodule

// File: rtl/simd_int_unit_chk.sv
module simd_int_unit_chk #(
  parameter int DATA_W  = 256,
  parameter int TAG_W   = 5,
  parameter int IMM_W   = 5,
  parameter int MUL_LAT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [1:0]        in_esz,
  input logic [IMM_W-1:0]  in_imm,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [TAG_W-1:0]  in_tag,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [TAG_W-1:0]  out_tag
);

  localparam logic [2:0] MUL_CODE = 3'd5;

  logic              acc_short;
  logic              acc_mul;
  logic              short_q;
  logic [MUL_LAT-1:0] mul_sh;

  assign acc_short = in_valid && in_ready && (in_op != MUL_CODE);
  assign acc_mul   = in_valid && in_ready && (in_op == MUL_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q <= 1'b0;
      mul_sh  <= '0;
    end else begin
      short_q <= acc_short;
      mul_sh  <= {mul_sh[MUL_LAT-2:0], acc_mul};
    end
  end

  p_completion_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (short_q || mul_sh[MUL_LAT-1]));

  p_mul_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mul_sh[MUL_LAT-1] |-> out_valid);

  p_mul_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == MUL_CODE) |-> in_ready);

  p_collision_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != MUL_CODE && mul_sh[MUL_LAT-2]) |-> !in_ready);

  p_short_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_short |=> (out_tag == $past(in_tag)));

  p_add8_lane0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_short && in_op == 3'd0 && in_esz == 2'd0) |=>
      (out_data[7:0] == $past(in_a[7:0] + in_b[7:0])));

  p_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_short && in_op == 3'd1) |=> (out_data == $past(in_a ^ in_b)));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r10: assert (!out_valid);
    end
  end

endmodule

bind simd_int_unit simd_int_unit_chk #(
  .DATA_W  (DATA_W),
  .TAG_W   (TAG_W),
  .IMM_W   (IMM_W),
  .MUL_LAT (MUL_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_esz    (in_esz),
  .in_imm    (in_imm),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_tag    (in_tag),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_tag   (out_tag)
);

// File: tb/simd_int_unit_tb.sv
module simd_int_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;
  localparam int NST        = LAT - 1;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [2:0]   in_op;
  logic [1:0]   in_esz;
  logic [4:0]   in_imm;
  logic [255:0] in_a;
  logic [255:0] in_b;
  logic [4:0]   in_tag;
  logic         out_valid;
  logic [255:0] out_data;
  logic [4:0]   out_tag;

  int tests;
  int fails;
  bit finished;

  simd_int_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_esz    (in_esz),
    .in_imm    (in_imm),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_tag    (in_tag),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit           mv [NST];
  logic [255:0] md [NST];
  logic [4:0]   mt [NST];
  string        mr [NST];
  bit           ev;
  logic [255:0] ed;
  logic [4:0]   et;
  string        er;

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [255:0] ref_calc(input logic [2:0] op, input logic [1:0] esz,
                                            input logic [4:0] imm,
                                            input logic [255:0] a, input logic [255:0] b);
    int ew;
    int n;
    logic [63:0] mask;
    logic [63:0] ea, eb, v, ix;
    logic signed [63:0] sa, sb, si;
    logic [255:0] r;
    ew   = 8 << esz;
    n    = 256 / ew;
    mask = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
    ix   = {{59{imm[4]}}, imm};
    r    = '0;
    for (int i = 0; i < n; i++) begin
      ea = 64'(a >> (i*ew)) & mask;
      eb = 64'(b >> (i*ew)) & mask;
      sa = $signed(ea << (64-ew)) >>> (64-ew);
      sb = $signed(eb << (64-ew)) >>> (64-ew);
      si = $signed(ix);
      case (op)
        3'd0: v = ea + eb;
        3'd1: v = ea ^ eb;
        3'd2: v = ea << (eb & 64'(ew-1));
        3'd3: v = (sa > sb) ? ea : eb;
        3'd4: v = (sa > si) ? ea : ix;
        default: v = ea * eb;
      endcase
      r = r | (256'(v & mask) << (i*ew));
    end
    return r;
  endfunction

  task automatic check_out();
    tests++;
    if (out_valid !== ev) begin
      fails++;
      $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, ev);
    end else if (ev) begin
      if (out_tag !== et) begin
        fails++;
        $display("FAIL R9 out_tag actual=%0h expected=%0h", out_tag, et);
      end else if (out_data !== ed) begin
        fails++;
        $display("FAIL %s out_data actual=%h expected=%h", er, out_data, ed);
      end
    end
  endtask

  // one cycle: drive at negedge, check ready, advance model, compare after the edge
  task automatic step(input bit v, input logic [2:0] op, input logic [1:0] esz,
                      input logic [4:0] imm, input logic [255:0] a, input logic [255:0] b,
                      input logic [4:0] tag, output bit acc);
    bit exp_rdy;
    in_valid = v; in_op = op; in_esz = esz; in_imm = imm;
    in_a = a; in_b = b; in_tag = tag;
    #1;
    exp_rdy = !(mv[NST-1] && op != 3'd5);
    tests++;
    if (in_ready !== exp_rdy) begin
      fails++;
      $display("FAIL R8 in_ready actual=%0b expected=%0b", in_ready, exp_rdy);
    end
    acc = v && exp_rdy;
    if (acc && op != 3'd5) begin
      ev = 1; ed = ref_calc(op, esz, imm, a, b); et = tag; er = req_of(op);
    end else if (mv[NST-1]) begin
      ev = 1; ed = md[NST-1]; et = mt[NST-1]; er = mr[NST-1];
    end else begin
      ev = 0;
    end
    for (int s = NST-1; s > 0; s--) begin
      mv[s] = mv[s-1]; md[s] = md[s-1]; mt[s] = mt[s-1]; mr[s] = mr[s-1];
    end
    mv[0] = acc && op == 3'd5;
    md[0] = ref_calc(op, esz, imm, a, b);
    mt[0] = tag;
    mr[0] = "R7";
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] esz, input logic [4:0] imm,
                       input logic [255:0] a, input logic [255:0] b, input logic [4:0] tag);
    bit acc;
    acc = 0;
    while (!acc) step(1, op, esz, imm, a, b, tag, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(0, 3'd0, 2'd0, 5'd0, '0, '0, 5'd0, acc);
  endtask

  task automatic do_reset();
    rst_n = 0;
    in_valid = 0;
    for (int s = 0; s < NST; s++) mv[s] = 0;
    ev = 0;
    @(posedge clk);
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 during reset out_valid=%0b in_ready=%0b expected 0 and 1",
               out_valid, in_ready);
    end
    rst_n = 1;
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    tests = 0; fails = 0; finished = 0;
    rst_n = 0; in_valid = 0; in_op = '0; in_esz = '0; in_imm = '0;
    in_a = '0; in_b = '0; in_tag = '0;
    @(negedge clk);
    do_reset();
    idle(2);

    // R1: every lane width with each single-cycle operation and edge patterns
    for (int e = 0; e < 4; e++) begin
      for (int o = 0; o < 5; o++) begin
        issue(3'(o), 2'(e), 5'b10001, {32{8'h80}}, {32{8'hFF}}, 5'(o + 5*e));
        issue(3'(o), 2'(e), 5'b01111, {32{8'h7F}}, {32{8'h01}}, 5'(o + 1));
        issue(3'(o), 2'(e), 5'b10000, rnd256(), {32{8'hE7}}, 5'(o + 2));
        issue(3'(o), 2'(e), 5'b00000, {64{4'h0}}, rnd256(), 5'(o + 3));
      end
    end

    // R4: upper bits of the shift lane ignored
    issue(3'd2, 2'd0, 5'd0, {32{8'h01}}, {32{8'hF9}}, 5'd7);
    issue(3'd2, 2'd3, 5'd0, {4{64'h1}}, {4{64'hFFFF_FFFF_FFFF_FFC3}}, 5'd8);

    // R6: immediate extremes against negative and positive lanes
    issue(3'd4, 2'd1, 5'b10000, {16{16'h8000}}, '0, 5'd9);
    issue(3'd4, 2'd2, 5'b01111, {8{32'hFFFF_FFF0}}, '0, 5'd10);

    // R7: back-to-back multiplies, all widths
    for (int e = 0; e < 4; e++)
      for (int k = 0; k < 3; k++) issue(3'd5, 2'(e), 5'd0, rnd256(), rnd256(), 5'(20 + k));
    idle(LAT);

    // R8: multiply followed by a stream of short ops, one stalls
    issue(3'd5, 2'd2, 5'd0, rnd256(), rnd256(), 5'd1);
    for (int k = 0; k < 5; k++) issue(3'd0, 2'd1, 5'd0, rnd256(), rnd256(), 5'(2 + k));
    issue(3'd5, 2'd0, 5'd0, rnd256(), rnd256(), 5'd11);
    issue(3'd3, 2'd0, 5'd0, rnd256(), rnd256(), 5'd12);
    issue(3'd5, 2'd3, 5'd0, rnd256(), rnd256(), 5'd13);
    issue(3'd1, 2'd0, 5'd0, rnd256(), rnd256(), 5'd14);
    issue(3'd2, 2'd2, 5'd0, rnd256(), rnd256(), 5'd15);
    issue(3'd4, 2'd1, 5'd3, rnd256(), rnd256(), 5'd16);
    idle(LAT);

    // R10: reset with multiplies in flight, nothing may appear afterwards
    issue(3'd5, 2'd0, 5'd0, rnd256(), rnd256(), 5'd30);
    issue(3'd5, 2'd1, 5'd0, rnd256(), rnd256(), 5'd31);
    do_reset();
    idle(LAT + 2);

    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      bit acc;
      int r;
      r = $urandom_range(0, 9);
      step(r != 0, 3'($urandom_range(0, 5)), 2'($urandom_range(0, 3)), 5'($urandom),
           rnd256(), rnd256(), 5'($urandom), acc);
    end
    idle(LAT + 1);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule